// File: doc/BRIEF.md
# Stretch-Tolerant I2C Clock Phase Generator

This block produces the SCL waveform for an I2C master and the timing strobes that a byte engine needs around it. It counts two programmable phase lengths, one for SCL low and one for SCL high. Both use a count clock, which is the module clock divided by a programmable ratio. The low phase starts counting in the same cycle that the block begins pulling SCL low. The high phase, by contrast, starts counting only after a two-stage synchroniser reports the line as actually high. Slow rise times and slaves that stretch the clock therefore lengthen the high interval rather than shortening it. There is no timeout while a slave holds the line.

The byte engine requests a START. The generator then times the START hold with SCL released and after that begins clocking. Clocking continues until the engine raises a finish request at the end of a low phase. The generator then releases SCL, times the STOP setup interval and returns to idle. During the low phase a strobe marks the point at which SDA may change. A second strobe marks the first cycle of each high phase, where data is sampled. A hold input lets the engine keep SCL low for as long as it needs. Each phase count is nine bits wide. The ninth bit arrives on its own input, separate from the lower byte.

Top module: `scl_phase_gen`

## Requirements
- R1: After synchronous reset, and for as long as no start request arrives, scl_pull is 0 and sda_slot, sample_slot, start_held and stop_ready are all 0.
- R2: A low phase drives scl_pull to 1 for exactly NL x D clock cycles. NL is the effective low count and D is the effective divide ratio.
- R3: In a high phase scl_pull is 0. Counting begins only when the synchronised SCL input is high, two cycles after the line rises. If the line is held low for S extra cycles after release, the high phase lasts S + 2 + NH x D cycles.
- R4: The count for each phase is {b8, lo[7:0]}, so the ninth bit adds 256 to the count.
- R5: A count of zero acts as a count of one, so each phase lasts at least one count-clock period.
- R6: A divide ratio of zero acts as a ratio of one.
- R7: sda_slot pulses exactly once per low phase. The pulse falls in cycle (floor(NL/2)+1) x D - 1, counted from 0 at the first pulled cycle.
- R8: sample_slot pulses exactly once per high phase, in the first cycle in which the synchronised input is high. That cycle has index S + 2.
- R9: A start_req in idle opens a released START hold of NH x D cycles, beginning in the cycle after the request. start_held pulses in the last cycle of the hold, and a low phase follows.
- R10: If finish_req is high when a low phase ends, the generator releases SCL and times a STOP setup. stop_ready pulses in cycle 1 + NH x D after release. The generator then stays idle with SCL released.
- R11: Each cycle of hold_low during a low phase freezes the count, so the low phase becomes one cycle longer per hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Begin START hold when idle |
| finish_req | input | 1 | Take STOP setup at end of current low phase |
| hold_low | input | 1 | Freeze the low phase |
| clk_div | input | DIV_W | Module clocks per count clock (0 means 1) |
| low_cnt_lo | input | 8 | Low count bits 7..0 |
| low_cnt_b8 | input | 1 | Low count bit 8 |
| high_cnt_lo | input | 8 | High count bits 7..0 |
| high_cnt_b8 | input | 1 | High count bit 8 |
| scl_in | input | 1 | Sensed SCL line level |
| scl_pull | output | 1 | 1 drives SCL low, 0 releases it |
| sda_slot | output | 1 | Pulse: SDA may change now |
| sample_slot | output | 1 | Pulse: sample SDA now |
| start_held | output | 1 | Pulse: START hold complete |
| stop_ready | output | 1 | Pulse: STOP setup complete |

## Verification
The assertions assume three things about the inputs. First, clk_div and the two counts stay constant while the generator is busy. Second, every low phase lasts at least two clock cycles, so the synchroniser sees the line fall before the high phase begins. Third, hold_low is raised only while SCL is being pulled low. The stimulus changes configuration only while the generator is idle. Every vector gives a low phase of two or more cycles. Hold pulses are placed inside the low phase, starting before the low phase would have ended. The line model releases SCL only after scl_pull falls, and any extra stretch comes after that.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

    // phase of the SCL sequencer
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SHOLD,   // START hold, SCL released
        PH_LOW,     // SCL pulled low
        PH_HIGH,    // SCL released, data high phase
        PH_PSET     // STOP setup, SCL released
    } phase_e;

    // strobes handed to the byte engine
    typedef struct packed {
        logic sda_slot;
        logic sample_slot;
        logic start_held;
        logic stop_ready;
    } slot_t;

endpackage

// File: rtl/scl_tg_tick.sv
module scl_tg_tick #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] dcnt;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (div == '0) ? DIV_W'(1) : div;
    assign tick    = en && (dcnt == div_eff - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            dcnt <= '0;
        else if (en)
            dcnt <= tick ? '0 : dcnt + DIV_W'(1);
    end

    // R6: after a count tick the divider restarts from zero
    a_r6_tick_wrap: assert property (@(posedge clk) disable iff (rst)
        tick |=> (dcnt == '0));

endmodule

// File: rtl/scl_tg_sync.sv
module scl_tg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '1;
        else
            sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_tg_pkg::*;
#(
    parameter int DIV_W    = 4,
    parameter int LO_W     = 8,
    parameter int SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             finish_req,
    input  logic             hold_low,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [LO_W-1:0]  low_cnt_lo,
    input  logic             low_cnt_b8,
    input  logic [LO_W-1:0]  high_cnt_lo,
    input  logic             high_cnt_b8,
    input  logic             scl_in,
    output logic             scl_pull,
    output logic             sda_slot,
    output logic             sample_slot,
    output logic             start_held,
    output logic             stop_ready
);
    localparam int CNT_W = LO_W + 1;

    phase_e           state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] low_eff, high_eff, target;
    logic             scl_s;
    logic             released, run, tick, last, dclr, seen_q;
    slot_t            slots;

    // R4, R5: nine-bit counts, zero behaves as one
    function automatic logic [CNT_W-1:0] eff_cnt(input logic msb, input logic [LO_W-1:0] lo);
        logic [CNT_W-1:0] v;
        v = {msb, lo};
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    assign low_eff  = eff_cnt(low_cnt_b8, low_cnt_lo);
    assign high_eff = eff_cnt(high_cnt_b8, high_cnt_lo);
    assign target   = (state == PH_LOW) ? low_eff : high_eff;

    scl_tg_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (scl_in),
        .q   (scl_s)
    );

    // released phases count only once the line is seen high (R3)
    assign released = (state == PH_SHOLD) || (state == PH_HIGH) || (state == PH_PSET);
    assign run      = (state == PH_LOW) ? !hold_low : (released && scl_s);

    scl_tg_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (dclr),
        .en   (run),
        .div  (clk_div),
        .tick (tick)
    );

    assign last = tick && (cnt == target - CNT_W'(1));

    always_comb begin
        state_nxt = state;
        case (state)
            PH_IDLE:  if (start_req) state_nxt = PH_SHOLD;
            PH_SHOLD: if (last)      state_nxt = PH_LOW;
            PH_LOW:   if (last)      state_nxt = finish_req ? PH_PSET : PH_HIGH;
            PH_HIGH:  if (last)      state_nxt = PH_LOW;
            PH_PSET:  if (last)      state_nxt = PH_IDLE;
            default:                 state_nxt = PH_IDLE;
        endcase
    end

    assign dclr = (state != state_nxt) || (state == PH_IDLE) || (released && !scl_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PH_IDLE;
            cnt    <= '0;
            seen_q <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state != state_nxt || (released && !scl_s))
                cnt <= '0;
            else if (tick)
                cnt <= cnt + CNT_W'(1);
            if (state != state_nxt)
                seen_q <= 1'b0;
            else if (state == PH_HIGH && scl_s)
                seen_q <= 1'b1;
        end
    end

    always_comb begin
        slots.sda_slot    = (state == PH_LOW) && tick && (cnt == (low_eff >> 1));
        slots.sample_slot = (state == PH_HIGH) && scl_s && !seen_q;
        slots.start_held  = (state == PH_SHOLD) && last;
        slots.stop_ready  = (state == PH_PSET) && last;
    end

    assign scl_pull    = (state == PH_LOW);
    assign sda_slot    = slots.sda_slot;
    assign sample_slot = slots.sample_slot;
    assign start_held  = slots.start_held;
    assign stop_ready  = slots.stop_ready;

    // R2: the phase counter never reaches its target
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (state != PH_IDLE) |-> (cnt < target));

    // R3: a high phase cannot end while the line is still seen low
    a_r3_wait_high: assert property (@(posedge clk) disable iff (rst)
        (state == PH_HIGH && !scl_s) |=> (state == PH_HIGH));

    // R8: the sample strobe is a single-cycle pulse
    a_r8_sample_once: assert property (@(posedge clk) disable iff (rst)
        sample_slot |=> !sample_slot);

    // R9: the START hold is followed by a low phase
    a_r9_start_to_low: assert property (@(posedge clk) disable iff (rst)
        start_held |=> scl_pull);

    // R10: after STOP setup the generator sits idle with SCL released
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (rst)
        stop_ready |=> (!scl_pull && state == PH_IDLE));

    // R11: hold freezes the low-phase count
    a_r11_hold_freeze: assert property (@(posedge clk) disable iff (rst)
        (state == PH_LOW && hold_low) |=> (state == PH_LOW && $stable(cnt)));

endmodule

// File: tb/sim_scl_phase_gen.sv
module sim_scl_phase_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic       finish_req = 1'b0;
    logic       hold_low = 1'b0;
    logic [3:0] clk_div = 4'd1;
    logic [7:0] low_cnt_lo = 8'd4;
    logic       low_cnt_b8 = 1'b0;
    logic [7:0] high_cnt_lo = 8'd4;
    logic       high_cnt_b8 = 1'b0;
    logic       stretch = 1'b0;
    logic       scl_line;
    logic       scl_pull, sda_slot, sample_slot, start_held, stop_ready;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    // open-drain line: low if we pull or a slave stretches
    assign scl_line = !scl_pull && !stretch;

    scl_phase_gen u0 (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .finish_req  (finish_req),
        .hold_low    (hold_low),
        .clk_div     (clk_div),
        .low_cnt_lo  (low_cnt_lo),
        .low_cnt_b8  (low_cnt_b8),
        .high_cnt_lo (high_cnt_lo),
        .high_cnt_b8 (high_cnt_b8),
        .scl_in      (scl_line),
        .scl_pull    (scl_pull),
        .sda_slot    (sda_slot),
        .sample_slot (sample_slot),
        .start_held  (start_held),
        .stop_ready  (stop_ready)
    );

    // {low count, high count, divide, stretch, hold start, hold length}
    localparam int VEC [4][6] = '{
        '{10,  8, 1, 0,  3, 2},
        '{ 7,  5, 2, 3,  4, 0},
        '{20, 12, 3, 5, 10, 4},
        '{ 3,  4, 4, 0,  0, 6}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input int nl, input int nh, input int d, input int s,
                            input int ha, input int hl, input string tag);
        int nle, nhe, de, n, idx, cnt;
        nle = (nl == 0) ? 1 : nl;
        nhe = (nh == 0) ? 1 : nh;
        de  = (d == 0) ? 1 : d;
        low_cnt_lo  = 8'(nl);
        low_cnt_b8  = 1'(nl >> 8);
        high_cnt_lo = 8'(nh);
        high_cnt_b8 = 1'(nh >> 8);
        clk_div     = 4'(d);
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        // START hold
        n = 0; idx = -1;
        while (!scl_pull) begin
            if (start_held) idx = n;
            @(negedge clk); n++;
        end
        check({tag, " R9 start hold length"}, n, nhe * de);
        check({tag, " R9 start_held index"}, idx, nhe * de - 1);
        // first low phase
        stretch = (s > 0);
        n = 0; idx = -1; cnt = 0;
        while (scl_pull) begin
            if (sda_slot) begin cnt++; idx = n; end
            @(negedge clk); n++;
        end
        check({tag, " low length"}, n, nle * de);
        check({tag, " R7 sda_slot count"}, cnt, 1);
        check({tag, " R7 sda_slot index"}, idx, (nle / 2 + 1) * de - 1);
        // high phase with optional stretch
        n = 0; idx = -1; cnt = 0;
        while (!scl_pull) begin
            if (n == s) stretch = 1'b0;
            if (sample_slot) begin cnt++; idx = n; end
            @(negedge clk); n++;
        end
        check({tag, " R3 high length"}, n, s + 2 + nhe * de);
        check({tag, " R8 sample count"}, cnt, 1);
        check({tag, " R8 sample index"}, idx, s + 2);
        // second low phase with hold, then finish
        finish_req = 1'b1;
        n = 0;
        while (scl_pull) begin
            if (n == ha) hold_low = (hl > 0);
            if (n == ha + hl) hold_low = 1'b0;
            @(negedge clk); n++;
        end
        hold_low = 1'b0;
        check({tag, " R11 held low length"}, n, nle * de + hl);
        // STOP setup
        n = 0;
        while (!stop_ready) begin
            @(negedge clk); n++;
        end
        finish_req = 1'b0;
        check({tag, " R10 stop_ready index"}, n, 1 + nhe * de);
        cnt = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (scl_pull) cnt++;
        end
        check({tag, " R10 idle after stop"}, cnt, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, no activity without a start
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            if (scl_pull || sda_slot || sample_slot || start_held || stop_ready) bad++;
            @(negedge clk);
        end
        check("R1 idle after reset", bad, 0);

        for (int i = 0; i < 4; i++)
            run_case(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], "R2");

        // R4: ninth bits of both counts
        run_case(260, 257, 1, 2, 100, 3, "R4");
        // R5: zero counts act as one
        run_case(0, 0, 3, 1, 0, 0, "R5");
        // R6: zero divide acts as one
        run_case(5, 3, 0, 0, 1, 1, "R6");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule